// File: doc/BRIEF.md
# Single-Outstanding DMA Request Controller

This controller sits between a DMA sequencer and a memory directory. It takes one load or store request at a time from the sequencer, turns it into a directory request that carries the sequencer's addresses, data block and length, and tags it as a read or a write together with a fixed requester identifier. Each request leaves after a fixed delay, and no further sequencer request is accepted until the directory answers.

A load is closed only by a data response, which returns the data block to the sequencer on a one-cycle completion strobe. A store is closed only by an acknowledge, which raises a one-cycle write-complete strobe. A response of the wrong kind for the current state sets a sticky protocol error and is dropped. A request or response whose type code is not defined produces a one-cycle error pulse and is dropped. Every port uses a valid/ready handshake, and the response port is always ready.

Top module: `dma_single_ctrl`

## Requirements
- R1: After reset the controller is idle: `seq_ready`=1, `rsp_ready`=1, and `dir_valid`, `rd_done_valid`, `wr_done`, `bad_type` and `protocol_error` are all 0.
- R2: A sequencer request with `seq_kind`=2'b01 (load) is taken in a cycle where `seq_ready`=1. `seq_ready` then drops. Exactly LATENCY (default 6) clock edges after the accepting edge, `dir_valid` rises with `dir_op`=0 (read), the request's physical address, line address, data and length, and `dir_src`=REQUESTER_ID.
- R3: A request with `seq_kind`=2'b10 (store) behaves as in R2, except that `dir_op`=1 (write).
- R4: While `dir_valid`=1 and `dir_ready`=0, `dir_valid` stays high and every directory field stays unchanged. The handshake edge clears `dir_valid`.
- R5: In the busy-read state, a response with `rsp_kind`=2'b01 (data) produces a one-cycle `rd_done_valid` with `rd_done_data` equal to `rsp_data`, and `seq_ready` returns to 1.
- R6: In the busy-write state, a response with `rsp_kind`=2'b10 (ack) produces a one-cycle `wr_done`, and `seq_ready` returns to 1.
- R7: A data or ack response that does not match the current state, including one that arrives while idle, sets `protocol_error`. The flag stays at 1 until reset. The response is dropped and the state is unchanged.
- R8: A sequencer request with `seq_kind` 2'b00 or 2'b11 is consumed and dropped. `bad_type` pulses for one cycle, no directory request follows, and `seq_ready` stays 1.
- R9: A response with `rsp_kind` 2'b00 or 2'b11 is dropped. `bad_type` pulses for one cycle, and the busy state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Sequencer request valid |
| seq_ready | output | 1 | Controller can take a request |
| seq_kind | input | 2 | 01 load, 10 store, other codes invalid |
| seq_paddr | input | PA_W | Physical address |
| seq_laddr | input | LA_W | Line address |
| seq_data | input | DATA_W | Data block |
| seq_len | input | LEN_W | Transfer length |
| dir_valid | output | 1 | Directory request valid |
| dir_ready | input | 1 | Directory accepts request |
| dir_op | output | 1 | 0 read, 1 write |
| dir_paddr | output | PA_W | Copied physical address |
| dir_laddr | output | LA_W | Copied line address |
| dir_data | output | DATA_W | Copied data block |
| dir_len | output | LEN_W | Copied length |
| dir_src | output | ID_W | Requester identifier |
| rsp_valid | input | 1 | Directory response valid |
| rsp_ready | output | 1 | Response accepted (always 1) |
| rsp_kind | input | 2 | 01 data, 10 ack, other codes invalid |
| rsp_data | input | DATA_W | Response data block |
| rd_done_valid | output | 1 | Read-completion strobe |
| rd_done_data | output | DATA_W | Returned data block |
| wr_done | output | 1 | Write-completion strobe |
| bad_type | output | 1 | One-cycle pulse on an invalid type code |
| protocol_error | output | 1 | Sticky flag for a mismatched response |

## Verification
Loads and stores are each run with directory back-pressure of zero to three cycles. Distinct address, data and length values per run show whether fields are copied from the right source and held under stall, and cycle-exact sampling shows whether the release delay is exactly six edges. Some runs inject a response of the wrong kind, and then one with an undefined kind, before the matching response. These runs separate a sticky mismatch from a transient type error, and show that neither closes a busy state. Both undefined request codes are also sent, to confirm that nothing reaches the directory for them.

// File: rtl/dma_single_ctrl.sv
module dma_single_ctrl #(
  parameter int PA_W = 16,
  parameter int LA_W = 12,
  parameter int DATA_W = 32,
  parameter int LEN_W = 4,
  parameter int ID_W = 4,
  parameter int REQUESTER_ID = 5,
  parameter int LATENCY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_valid,
  output logic              seq_ready,
  input  logic [1:0]        seq_kind,
  input  logic [PA_W-1:0]   seq_paddr,
  input  logic [LA_W-1:0]   seq_laddr,
  input  logic [DATA_W-1:0] seq_data,
  input  logic [LEN_W-1:0]  seq_len,
  output logic              dir_valid,
  input  logic              dir_ready,
  output logic              dir_op,
  output logic [PA_W-1:0]   dir_paddr,
  output logic [LA_W-1:0]   dir_laddr,
  output logic [DATA_W-1:0] dir_data,
  output logic [LEN_W-1:0]  dir_len,
  output logic [ID_W-1:0]   dir_src,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_done_valid,
  output logic [DATA_W-1:0] rd_done_data,
  output logic              wr_done,
  output logic              bad_type,
  output logic              protocol_error
);
  localparam int CW = $clog2(LATENCY + 1);

  typedef enum logic [1:0] {S_READY, S_BUSY_RD, S_BUSY_WR} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          pending;

  wire req_load  = seq_kind == 2'b01;
  wire req_store = seq_kind == 2'b10;
  wire seq_fire  = seq_valid && seq_ready;
  wire dir_fire  = dir_valid && dir_ready;

  assign seq_ready = (state == S_READY) && !pending;
  assign rsp_ready = 1'b1;
  assign dir_valid = pending && (cnt == '0);
  assign dir_src   = ID_W'(REQUESTER_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_READY;
      cnt            <= '0;
      pending        <= 1'b0;
      dir_op         <= 1'b0;
      dir_paddr      <= '0;
      dir_laddr      <= '0;
      dir_data       <= '0;
      dir_len        <= '0;
      rd_done_valid  <= 1'b0;
      rd_done_data   <= '0;
      wr_done        <= 1'b0;
      bad_type       <= 1'b0;
      protocol_error <= 1'b0;
    end else begin
      rd_done_valid <= 1'b0;
      wr_done       <= 1'b0;
      bad_type      <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (dir_fire) pending <= 1'b0;

      if (seq_fire) begin
        if (req_load || req_store) begin
          dir_op    <= req_store;
          dir_paddr <= seq_paddr;
          dir_laddr <= seq_laddr;
          dir_data  <= seq_data;
          dir_len   <= seq_len;
          pending   <= 1'b1;
          cnt       <= CW'(LATENCY);
          state     <= req_load ? S_BUSY_RD : S_BUSY_WR;
        end else begin
          bad_type <= 1'b1;
        end
      end

      if (rsp_valid) begin
        case (rsp_kind)
          2'b01:
            if (state == S_BUSY_RD) begin
              rd_done_valid <= 1'b1;
              rd_done_data  <= rsp_data;
              state         <= S_READY;
            end else protocol_error <= 1'b1;
          2'b10:
            if (state == S_BUSY_WR) begin
              wr_done <= 1'b1;
              state   <= S_READY;
            end else protocol_error <= 1'b1;
          default: bad_type <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_single_ctrl_chk.sv
module dma_single_ctrl_chk #(
  parameter int PA_W = 16,
  parameter int LA_W = 12,
  parameter int DATA_W = 32,
  parameter int LEN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_valid,
  input logic              seq_ready,
  input logic [1:0]        seq_kind,
  input logic              dir_valid,
  input logic              dir_ready,
  input logic              dir_op,
  input logic [PA_W-1:0]   dir_paddr,
  input logic [LA_W-1:0]   dir_laddr,
  input logic [DATA_W-1:0] dir_data,
  input logic [LEN_W-1:0]  dir_len,
  input logic              rd_done_valid,
  input logic              wr_done,
  input logic              bad_type,
  input logic              protocol_error
);
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && seq_ready && (seq_kind == 2'b01 || seq_kind == 2'b10) |=> !seq_ready);

  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid && !dir_ready |=> dir_valid && $stable(dir_op) && $stable(dir_paddr)
      && $stable(dir_laddr) && $stable(dir_data) && $stable(dir_len));

  a_r4_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid && dir_ready |=> !dir_valid);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);

  a_r8_drop_bad_req: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && seq_ready && (seq_kind == 2'b00 || seq_kind == 2'b11) |=> seq_ready && bad_type);

  a_r5_one_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_done_valid, wr_done}));
endmodule

bind dma_single_ctrl dma_single_ctrl_chk #(
  .PA_W(PA_W), .LA_W(LA_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) i_chk (.*);

// File: tb/test_dma_single_ctrl.sv
module test_dma_single_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 16, LA_W = 12, DATA_W = 32, LEN_W = 4, ID_W = 4, RID = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_valid = 1'b0, seq_ready;
  logic [1:0] seq_kind = '0;
  logic [PA_W-1:0] seq_paddr = '0;
  logic [LA_W-1:0] seq_laddr = '0;
  logic [DATA_W-1:0] seq_data = '0;
  logic [LEN_W-1:0] seq_len = '0;
  logic dir_valid, dir_ready = 1'b0, dir_op;
  logic [PA_W-1:0] dir_paddr;
  logic [LA_W-1:0] dir_laddr;
  logic [DATA_W-1:0] dir_data;
  logic [LEN_W-1:0] dir_len;
  logic [ID_W-1:0] dir_src;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [1:0] rsp_kind = '0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic rd_done_valid, wr_done, bad_type, protocol_error;
  logic [DATA_W-1:0] rd_done_data;

  int checks = 0, errors = 0;
  logic pe_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_single_ctrl #(.PA_W(PA_W), .LA_W(LA_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                    .ID_W(ID_W), .REQUESTER_ID(RID), .LATENCY(6)) i_dma_single_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rsp(input logic [1:0] k, input logic [DATA_W-1:0] d);
    @(negedge clk); rsp_valid = 1'b1; rsp_kind = k; rsp_data = d;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic txn(input logic [1:0] k, input int seed, input int hold, input bit inject);
    logic [PA_W-1:0] pa = PA_W'(16'h1000 + seed * 16'h0111);
    logic [LA_W-1:0] la = LA_W'(12'h040 + seed * 12'h013);
    logic [DATA_W-1:0] d = 32'hA5000000 ^ (32'(seed) * 32'h01030507);
    logic [LEN_W-1:0] ln = LEN_W'(seed + 1);
    string tg = (k == 2'b01) ? "R2" : "R3";
    @(negedge clk);
    seq_valid = 1'b1; seq_kind = k; seq_paddr = pa; seq_laddr = la; seq_data = d; seq_len = ln;
    chk(seq_ready == 1'b1, "R2 ready when idle", seq_ready, 1);
    @(negedge clk); seq_valid = 1'b0;
    chk(seq_ready == 1'b0, "R2 ready drops", seq_ready, 0);
    for (int i = 0; i < 5; i++) begin
      chk(dir_valid == 1'b0, {tg, " early release"}, dir_valid, 0);
      @(negedge clk);
    end
    chk(dir_valid == 1'b0, {tg, " early release"}, dir_valid, 0);
    @(negedge clk);
    chk(dir_valid == 1'b1, {tg, " release at 6"}, dir_valid, 1);
    chk(dir_op == (k == 2'b10), {tg, " op"}, dir_op, k == 2'b10);
    chk(dir_paddr == pa && dir_laddr == la, {tg, " addr"}, {dir_paddr, dir_laddr}, {pa, la});
    chk(dir_data == d && dir_len == ln, {tg, " data/len"}, {dir_data, dir_len}, {d, ln});
    chk(dir_src == ID_W'(RID), {tg, " src"}, dir_src, RID);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(dir_valid && dir_data == d && dir_paddr == pa && dir_len == ln,
          "R4 stall hold", dir_data, d);
    end
    dir_ready = 1'b1;
    @(negedge clk); dir_ready = 1'b0;
    chk(dir_valid == 1'b0, "R4 cleared", dir_valid, 0);
    if (inject) begin
      rsp((k == 2'b01) ? 2'b10 : 2'b01, ~d);
      pe_exp = 1'b1;
      chk(protocol_error == 1'b1, "R7 mismatch flagged", protocol_error, 1);
      chk(seq_ready == 1'b0 && !rd_done_valid && !wr_done, "R7 state kept", seq_ready, 0);
      rsp(2'b11, d);
      chk(bad_type == 1'b1, "R9 bad rsp pulse", bad_type, 1);
      chk(seq_ready == 1'b0, "R9 state kept", seq_ready, 0);
    end
    rsp(k, ~d);
    if (k == 2'b01) begin
      chk(rd_done_valid == 1'b1 && wr_done == 1'b0, "R5 read done", rd_done_valid, 1);
      chk(rd_done_data == ~d, "R5 data", rd_done_data, ~d);
    end else begin
      chk(wr_done == 1'b1 && rd_done_valid == 1'b0, "R6 write done", wr_done, 1);
    end
    chk(seq_ready == 1'b1, "R5/R6 back to idle", seq_ready, 1);
    chk(protocol_error == pe_exp, "R7 sticky value", protocol_error, pe_exp);
    @(negedge clk);
    chk(!rd_done_valid && !wr_done, "R5 R6 strobe one cycle", {rd_done_valid, wr_done}, 0);
  endtask

  task automatic bad_req(input logic [1:0] k);
    @(negedge clk); seq_valid = 1'b1; seq_kind = k;
    chk(seq_ready == 1'b1, "R8 ready", seq_ready, 1);
    @(negedge clk); seq_valid = 1'b0;
    chk(bad_type == 1'b1 && seq_ready == 1'b1, "R8 pulse and idle", {bad_type, seq_ready}, 3);
    @(negedge clk);
    chk(bad_type == 1'b0, "R8 one cycle", bad_type, 0);
    for (int i = 0; i < 8; i++) begin
      chk(dir_valid == 1'b0, "R8 no request", dir_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(seq_ready && rsp_ready && !dir_valid, "R1 reset idle", {seq_ready, rsp_ready, dir_valid}, 6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_done_valid && !wr_done && !bad_type && !protocol_error, "R1 outputs low",
        {rd_done_valid, wr_done, bad_type, protocol_error}, 0);
    for (int op = 0; op < 2; op++)
      for (int h = 0; h < 4; h++)
        txn(op == 0 ? 2'b01 : 2'b10, op * 4 + h, h, 1'b0);
    bad_req(2'b00);
    bad_req(2'b11);
    chk(protocol_error == 1'b0, "R7 clean so far", protocol_error, 0);
    txn(2'b01, 11, 1, 1'b1);
    txn(2'b10, 12, 2, 1'b1);
    rsp(2'b01, 32'h1);
    chk(protocol_error == 1'b1 && seq_ready == 1'b1 && !rd_done_valid, "R7 idle response",
        {protocol_error, seq_ready, rd_done_valid}, 6);
    txn(2'b10, 13, 0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule